// File: doc/BRIEF.md
# Edge-Selectable Quadrature Position Counter

This block turns two asynchronous digital inputs, A and B, into a wrapping position count. In pulse mode only A matters: every selected edge on A adds one to the count. In quadrature mode the two inputs are read as a phase pair, and every selected edge on either line is turned into a step up or a step down. The phase of the other line decides which. A two-bit edge selector picks rising, falling or both edges. With a single edge type selected, a quadrature pair gives half the resolution of the full four-step decode.

The count runs from zero up to a programmable limit and wraps at both ends. The host sets the mode, the edge selector and the limit while the counter is stopped, and then raises the run input. A configuration write made while the counter runs is refused and flagged. Raising run clears the count. A direction output shows whether the latest step went up or down. A sticky flag records any cycle in which both quadrature inputs changed at once.

Top module: `qdec_counter`

## Requirements
- R1: After reset the count is 0, the direction output is 1 (up), both error flags are 0, the limit holds the all-ones value of the count width, and the mode is pulse with rising edges.
- R2: In pulse mode (cfg_quad = 0) every selected edge of A raises the count by one, and B has no effect.
- R3: The edge selector uses 0 for rising, 1 for falling and 2 for both edges. A write of the value 3 is refused: cfg_err_o is set and the previous configuration stays in force.
- R4: In quadrature mode with rising edges selected, a rising A steps up when B is low and down when B is high, and a rising B steps up when A is high and down when A is low. Falling edges cause no step.
- R5: In quadrature mode with falling edges selected, a falling A steps up when B is high and down when B is low, and a falling B steps up when A is low and down when A is high. Rising edges cause no step.
- R6: In quadrature mode with both edges selected, the rules of R4 and R5 both apply, so one full input cycle gives four steps.
- R7: A step up from the limit gives 0, and a step down from 0 gives the limit. While running, the count never exceeds the limit.
- R8: A configuration write (cfg_wr = 1) while the counter is running is refused and sets cfg_err_o. The next accepted write, made while stopped, clears cfg_err_o.
- R9: The cycle in which run rises clears the count to 0 and sets the direction output to up. While run is low, input edges leave the count unchanged.
- R10: In quadrature mode, if A and B both change in the same sampled cycle, the count does not change and phase_err_o is set. The flag stays set until the next rise of run.
- R11: dir_up_o shows the direction of the most recent step: 1 for up, 0 for down.
- R12: In quadrature mode with both edges selected, if one input holds still while the other toggles, the count alternates between two values and never drifts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| run | input | 1 | Counter runs while high; configuration is locked |
| cfg_wr | input | 1 | One-cycle configuration write strobe |
| cfg_quad | input | 1 | 1 selects quadrature mode, 0 selects pulse mode |
| cfg_edge | input | 2 | Edge selector: 0 rising, 1 falling, 2 both |
| cfg_limit | input | CNT_W | Wrap limit (highest count value) |
| a_in | input | 1 | Asynchronous input A |
| b_in | input | 1 | Asynchronous input B |
| count_o | output | CNT_W | Current count |
| dir_up_o | output | 1 | Direction of the latest step, 1 = up |
| cfg_err_o | output | 1 | Sticky: last configuration write was refused |
| phase_err_o | output | 1 | Sticky: simultaneous change on A and B was seen |

## Verification
Each input passes through two synchronizer flops and an edge register, so a change on A or B reaches count_o on the third rising clock edge. A wrong decode, a wrong direction rule or a wrong edge selection therefore shows as a count that is off by one, or a flipped dir_up_o, within three cycles of the input step. A wrong limit register or wrap rule shows only when the count reaches a boundary. For that reason the stimulus drives the count through zero with the reset-default limit, and through a small programmed limit. A broken lock shows up later, as a wrap at a value the refused write should not have installed.

// File: rtl/qdec_counter.sv
module qdec_counter #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic             cfg_wr,
  input  logic             cfg_quad,
  input  logic [1:0]       cfg_edge,
  input  logic [CNT_W-1:0] cfg_limit,
  input  logic             a_in,
  input  logic             b_in,
  output logic [CNT_W-1:0] count_o,
  output logic             dir_up_o,
  output logic             cfg_err_o,
  output logic             phase_err_o
);
  localparam logic [1:0]       EDGE_RISE = 2'd0;
  localparam logic [1:0]       EDGE_FALL = 2'd1;
  localparam logic [1:0]       EDGE_BOTH = 2'd2;
  localparam logic [CNT_W-1:0] LIMIT_RST = {CNT_W{1'b1}};

  logic [1:0]       a_sync, b_sync;
  logic             a_prev, b_prev;
  logic             run_q;
  logic             quad_q;
  logic [1:0]       edge_q;
  logic [CNT_W-1:0] limit_q;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      a_sync <= '0;
      b_sync <= '0;
      a_prev <= 1'b0;
      b_prev <= 1'b0;
    end else begin
      a_sync <= {a_sync[0], a_in};
      b_sync <= {b_sync[0], b_in};
      a_prev <= a_sync[1];
      b_prev <= b_sync[1];
    end

  wire a_s    = a_sync[1];
  wire b_s    = b_sync[1];
  wire a_rise = a_s & ~a_prev;
  wire a_fall = ~a_s & a_prev;
  wire b_rise = b_s & ~b_prev;
  wire b_fall = ~b_s & b_prev;

  wire rise_on = (edge_q == EDGE_RISE) || (edge_q == EDGE_BOTH);
  wire fall_on = (edge_q == EDGE_FALL) || (edge_q == EDGE_BOTH);

  wire a_evt = (a_rise & rise_on) | (a_fall & fall_on);
  wire b_evt = (b_rise & rise_on) | (b_fall & fall_on);

  wire clash   = quad_q & (a_rise | a_fall) & (b_rise | b_fall);
  wire a_up    = a_rise ? ~b_s : b_s;
  wire b_up    = b_rise ? a_s : ~a_s;
  wire step    = quad_q ? ((a_evt | b_evt) & ~clash) : a_evt;
  wire step_up = ~quad_q | (a_evt ? a_up : b_up);

  wire start  = run & ~run_q;
  wire cfg_ok = cfg_wr & ~run_q & (cfg_edge != 2'd3);

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      run_q     <= 1'b0;
      quad_q    <= 1'b0;
      edge_q    <= EDGE_RISE;
      limit_q   <= LIMIT_RST;
      cfg_err_o <= 1'b0;
    end else begin
      run_q <= run;
      if (cfg_wr) cfg_err_o <= ~cfg_ok;
      if (cfg_ok) begin
        quad_q  <= cfg_quad;
        edge_q  <= cfg_edge;
        limit_q <= cfg_limit;
      end
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      count_o     <= '0;
      dir_up_o    <= 1'b1;
      phase_err_o <= 1'b0;
    end else if (start) begin
      count_o     <= '0;
      dir_up_o    <= 1'b1;
      phase_err_o <= 1'b0;
    end else if (run_q) begin
      if (clash) phase_err_o <= 1'b1;
      if (step) begin
        dir_up_o <= step_up;
        if (step_up) count_o <= (count_o == limit_q) ? '0 : count_o + 1'b1;
        else         count_o <= (count_o == '0) ? limit_q : count_o - 1'b1;
      end
    end
endmodule

// File: rtl/qdec_counter_chk.sv
module qdec_counter_chk #(
  parameter int CNT_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             run,
  input logic             run_q,
  input logic             cfg_wr,
  input logic [CNT_W-1:0] limit_q,
  input logic [CNT_W-1:0] count_o,
  input logic             dir_up_o,
  input logic             cfg_err_o,
  input logic             phase_err_o
);
  // R7
  count_in_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    run_q |-> count_o <= limit_q);

  // R8
  locked_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_wr && run_q) |=> (cfg_err_o && $stable(limit_q)));

  // R9
  start_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(run_q) |-> (count_o == '0 && dir_up_o));

  // R9
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!run_q && !$past(run_q)) |-> $stable(count_o));

  // R10
  phase_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(phase_err_o) && !$rose(run_q)) |-> phase_err_o);

  // R8
  run_lock_limit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (run_q && run) |=> $stable(limit_q));
endmodule

bind qdec_counter qdec_counter_chk #(.CNT_W(CNT_W)) chk_i (
  .clk(clk), .rst_n(rst_n), .run(run), .run_q(run_q), .cfg_wr(cfg_wr),
  .limit_q(limit_q), .count_o(count_o), .dir_up_o(dir_up_o),
  .cfg_err_o(cfg_err_o), .phase_err_o(phase_err_o)
);

// File: tb/qdec_counter_test.sv
module qdec_counter_test;
  localparam int W = 8;
  localparam int NV = 49;

  logic clk = 0, rst_n = 0, run = 0, cfg_wr = 0, cfg_quad = 0;
  logic [1:0] cfg_edge = 0;
  logic [W-1:0] cfg_limit = '1;
  logic a_in = 0, b_in = 0;
  logic [W-1:0] count_o;
  logic dir_up_o, cfg_err_o, phase_err_o;
  int applied = 0, bad = 0;

  always #10 clk = ~clk;

  qdec_counter #(.CNT_W(W)) uut (
    .clk(clk), .rst_n(rst_n), .run(run), .cfg_wr(cfg_wr), .cfg_quad(cfg_quad),
    .cfg_edge(cfg_edge), .cfg_limit(cfg_limit), .a_in(a_in), .b_in(b_in),
    .count_o(count_o), .dir_up_o(dir_up_o), .cfg_err_o(cfg_err_o),
    .phase_err_o(phase_err_o)
  );

  // {ctl[3:0], ab[1:0], count[7:0], dir}; ctl[3]=restart, ctl[2]=quad, ctl[1:0]=edge
  localparam logic [14:0] VEC [NV] = '{
    // R2 R3 pulse, rising
    {4'h8,2'b00,8'd0,1'b1}, {4'h0,2'b10,8'd1,1'b1}, {4'h0,2'b00,8'd1,1'b1},
    {4'h0,2'b01,8'd1,1'b1}, {4'h0,2'b11,8'd2,1'b1}, {4'h0,2'b00,8'd2,1'b1},
    {4'h0,2'b10,8'd3,1'b1},
    // R2 R3 pulse, falling
    {4'h9,2'b00,8'd0,1'b1}, {4'h0,2'b10,8'd0,1'b1}, {4'h0,2'b00,8'd1,1'b1},
    {4'h0,2'b10,8'd1,1'b1}, {4'h0,2'b00,8'd2,1'b1}, {4'h0,2'b01,8'd2,1'b1},
    // R2 R3 pulse, both
    {4'hA,2'b00,8'd0,1'b1}, {4'h0,2'b10,8'd1,1'b1}, {4'h0,2'b00,8'd2,1'b1},
    {4'h0,2'b01,8'd2,1'b1}, {4'h0,2'b00,8'd2,1'b1},
    // R4 R11 quadrature, rising
    {4'hC,2'b00,8'd0,1'b1}, {4'h0,2'b10,8'd1,1'b1}, {4'h0,2'b11,8'd2,1'b1},
    {4'h0,2'b01,8'd2,1'b1}, {4'h0,2'b00,8'd2,1'b1}, {4'h0,2'b10,8'd3,1'b1},
    {4'h0,2'b00,8'd3,1'b1}, {4'h0,2'b01,8'd2,1'b0}, {4'h0,2'b11,8'd1,1'b0},
    // R5 R11 quadrature, falling
    {4'hD,2'b11,8'd0,1'b1}, {4'h0,2'b01,8'd1,1'b1}, {4'h0,2'b00,8'd2,1'b1},
    {4'h0,2'b10,8'd2,1'b1}, {4'h0,2'b11,8'd2,1'b1}, {4'h0,2'b10,8'd1,1'b0},
    {4'h0,2'b00,8'd0,1'b0},
    // R6 R7 R1 R12 quadrature, both
    {4'hE,2'b00,8'd0,1'b1}, {4'h0,2'b10,8'd1,1'b1}, {4'h0,2'b11,8'd2,1'b1},
    {4'h0,2'b01,8'd3,1'b1}, {4'h0,2'b00,8'd4,1'b1}, {4'h0,2'b01,8'd3,1'b0},
    {4'h0,2'b11,8'd2,1'b0}, {4'h0,2'b10,8'd1,1'b0}, {4'h0,2'b00,8'd0,1'b0},
    {4'h0,2'b01,8'd255,1'b0}, {4'h0,2'b00,8'd0,1'b1}, {4'h0,2'b10,8'd1,1'b1},
    {4'h0,2'b00,8'd0,1'b0}, {4'h0,2'b10,8'd1,1'b1}, {4'h0,2'b00,8'd0,1'b0}
  };

  task automatic check(input string tag, input int act, input int exp);
    applied++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic settle();
    repeat (4) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic write_cfg(input logic q, input logic [1:0] e, input logic [W-1:0] lim);
    cfg_quad = q; cfg_edge = e; cfg_limit = lim; cfg_wr = 1;
    @(negedge clk);
    cfg_wr = 0;
    @(negedge clk);
  endtask

  task automatic restart(input logic q, input logic [1:0] e, input logic [W-1:0] lim,
                         input logic a, input logic b);
    run = 0; a_in = a; b_in = b;
    settle();
    write_cfg(q, e, lim);
    run = 1;
    repeat (2) @(negedge clk);
  endtask

  task automatic pulse_a();
    a_in = 1; settle();
    a_in = 0; settle();
  endtask

  initial begin
    #2_000_000;
    bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", applied, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    check("R1 count", count_o, 0);
    check("R1 dir", dir_up_o, 1);
    check("R1 cfg_err", cfg_err_o, 0);
    check("R1 phase_err", phase_err_o, 0);
    // R1: default pulse/rising config counts A rises without any write
    run = 1; repeat (2) @(negedge clk);
    pulse_a();
    check("R1 default mode", count_o, 1);

    for (int i = 0; i < NV; i++) begin
      logic [14:0] v;
      v = VEC[i];
      if (v[14]) begin
        restart(v[13], v[12:11], '1, v[10], v[9]);
      end else begin
        a_in = v[10]; b_in = v[9];
        settle();
      end
      check($sformatf("R2-R12 vector %0d count", i), count_o, v[8:1]);
      check($sformatf("R11 vector %0d dir", i), dir_up_o, v[0]);
    end

    // R7: small limit, pulse rising
    restart(1'b0, 2'd0, 8'd5, 1'b0, 1'b0);
    for (int k = 0; k < 5; k++) pulse_a();
    check("R7 at limit", count_o, 5);
    pulse_a();
    check("R7 wrap to zero", count_o, 0);

    // R8: write while running is refused, limit 5 kept
    write_cfg(1'b0, 2'd0, 8'd2);
    check("R8 busy flag", cfg_err_o, 1);
    for (int k = 0; k < 3; k++) pulse_a();
    check("R8 limit kept", count_o, 3);

    // R9: edges ignored while stopped
    run = 0; @(negedge clk);
    pulse_a();
    check("R9 hold while stopped", count_o, 3);
    write_cfg(1'b0, 2'd0, 8'd9);
    check("R8 flag cleared", cfg_err_o, 0);

    // R3: edge value 3 refused, rising config kept
    write_cfg(1'b0, 2'd3, 8'd9);
    check("R3 illegal edge flag", cfg_err_o, 1);
    run = 1; repeat (2) @(negedge clk);
    check("R9 start clears", count_o, 0);
    a_in = 1; settle();
    check("R3 rising still active", count_o, 1);
    a_in = 0; settle();
    check("R3 falling still ignored", count_o, 1);

    // R10: simultaneous change in quadrature
    restart(1'b1, 2'd2, '1, 1'b0, 1'b0);
    a_in = 1; b_in = 1; settle();
    check("R10 no step", count_o, 0);
    check("R10 flag set", phase_err_o, 1);
    b_in = 0; settle();
    check("R10 decode continues", count_o, 255);
    check("R10 flag sticky", phase_err_o, 1);
    run = 0; repeat (2) @(negedge clk);
    run = 1; repeat (2) @(negedge clk);
    check("R10 flag cleared on start", phase_err_o, 0);
    check("R9 count cleared on start", count_o, 0);

    $display("== %0d vectors applied, %0d miscompares ==", applied, bad);
    $finish;
  end
endmodule